// File: doc/BRIEF.md
# Debug Bus Match Comparator

This block is one comparator channel of an on-chip debug unit. It watches every processor bus cycle and compares the address, the data and the transfer direction with values loaded through a small register write port. A set of control bits decides which of these comparisons count and what a match does.

In immediate mode a match produces a trigger pulse for the state sequencer one clock after the bus cycle. In tag mode an address match only marks the opcode fetched from that address. The trigger then fires when the instruction queue reports that this opcode executes, and it never fires if the queue is flushed first. A break bit lets any match end the debug session at once, whatever the sequencer state. That match pulses a disarm output and, when the global breakpoint enable is set, a breakpoint output. The data inversion option is built only when the channel is configured as the first channel.

Top module: `dbg_match_channel`

## Requirements
- R1: After reset all three registers hold zero and every output is low. The enable bit is therefore clear and the comparator is disabled.
- R2: When the enable bit (control bit 0) is 0, the comparator gives no trigger and no tag. A pending tag is dropped.
- R3: An immediate match needs `bus_valid` high and `bus_addr` equal to the stored address over the full width.
- R4: When the direction-check bit (control bit 3) is 0, `bus_rd` plays no part in the comparison. When it is 1, a direction value (control bit 4) of 1 matches only read cycles (`bus_rd`=1) and a value of 0 matches only write cycles.
- R5: The data check (control bit 6) requires `bus_data` to equal the stored data. When the inversion bit (control bit 5) is also set, the data must differ from the stored data instead. A channel built with `HAS_INV`=0 ignores bit 5.
- R6: When the tag-select bit (control bit 1) is 0, a match pulses `trig_o` for one cycle, in the cycle after the bus cycle.
- R7: When the tag-select bit is 1, an address match on a valid bus cycle raises `tag_pend_o` in the next cycle and gives no trigger. The direction and data bits (3 to 6) are ignored in this mode.
- R8: While a tag is pending, `iq_exec` with `iq_exec_addr` equal to the stored address pulses `trig_o` in the next cycle and clears the tag. An execute at any other address fires nothing.
- R9: `iq_flush` clears a pending tag and no trigger follows. A flush in the same cycle as the execute wins over the execute.
- R10: Only one tag can be pending. Further address matches leave it pending, and one execute fires exactly one trigger.
- R11: When the break bit (control bit 2) is set, each match event (immediate or tagged execute) also pulses `disarm_o` and clears any pending tag.
- R12: `brk_o` pulses together with `disarm_o` only when `brk_enable` was high in the matching cycle. Otherwise the match only disarms.
- R13: `reg_we` with `reg_sel` set to 0 writes the control bits from `reg_wdata[6:0]`. `reg_sel` 1 writes the address and `reg_sel` 2 writes the data. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 data |
| reg_wdata | input | W | Register write data |
| bus_valid | input | 1 | A bus cycle is present |
| bus_rd | input | 1 | Bus cycle direction, 1 = read |
| bus_addr | input | W | Bus address |
| bus_data | input | W | Bus data |
| iq_exec | input | 1 | An opcode reaches the execute stage |
| iq_exec_addr | input | W | Address of the executing opcode |
| iq_flush | input | 1 | Instruction queue flush |
| brk_enable | input | 1 | Global breakpoint enable |
| trig_o | output | 1 | Trigger pulse to the state sequencer |
| tag_pend_o | output | 1 | A tagged opcode is pending |
| brk_o | output | 1 | Breakpoint pulse |
| disarm_o | output | 1 | Session termination / disarm pulse |

## Verification
The hardest cases to reach are in tag mode, where an execute and a flush meet a pending tag. The tag has to be set first, then reconfiguration, repeated address matches and queue events must reach it before it resolves. Directed sequences build each ordering: execute alone, flush alone, flush together with execute, a second match while the tag is pending, and an immediate-mode break that clears a leftover tag. A long random phase follows. It keeps addresses and data in a four-value window and sends frequent execute and flush events, so that tags, breaks and rewrites of the control register overlap often. Every output is compared in every cycle with a model built from the requirements, for a channel with inversion and one without.

// File: rtl/dbg_match_channel.sv
module dbg_match_channel #(
  parameter int W = 16,
  parameter bit HAS_INV = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [1:0]   reg_sel,
  input  logic [W-1:0] reg_wdata,
  input  logic         bus_valid,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_addr,
  input  logic [W-1:0] bus_data,
  input  logic         iq_exec,
  input  logic [W-1:0] iq_exec_addr,
  input  logic         iq_flush,
  input  logic         brk_enable,
  output logic         trig_o,
  output logic         tag_pend_o,
  output logic         brk_o,
  output logic         disarm_o
);
  localparam int CW = 7;

  logic [CW-1:0] ctl_q;
  logic [W-1:0]  cmp_addr_q;
  logic [W-1:0]  cmp_data_q;
  logic          tag_q;

  wire en     = ctl_q[0];
  wire tsel   = ctl_q[1];
  wire brk    = ctl_q[2];
  wire rw_chk = ctl_q[3];
  wire rw_val = ctl_q[4];
  wire inv    = ctl_q[5];
  wire dchk   = ctl_q[6];

  wire addr_hit = en && bus_valid && (bus_addr == cmp_addr_q);
  wire dir_ok   = !rw_chk || (bus_rd == rw_val);
  wire data_ok  = !dchk || ((bus_data == cmp_data_q) ^ inv);
  wire imm_hit  = addr_hit && !tsel && dir_ok && data_ok;
  wire tag_fire = en && tsel && tag_q && iq_exec && !iq_flush &&
                  (iq_exec_addr == cmp_addr_q);
  wire evt      = imm_hit || tag_fire;
  wire kill     = evt && brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      cmp_addr_q <= '0;
      cmp_data_q <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        2'd0: ctl_q <= {reg_wdata[6], reg_wdata[5] & HAS_INV, reg_wdata[4:0]};
        2'd1: cmp_addr_q <= reg_wdata;
        2'd2: cmp_data_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q    <= 1'b0;
      trig_o   <= 1'b0;
      disarm_o <= 1'b0;
      brk_o    <= 1'b0;
    end else begin
      trig_o   <= evt;
      disarm_o <= kill;
      brk_o    <= kill && brk_enable;
      if (!en || iq_flush || kill || tag_fire)
        tag_q <= 1'b0;
      else if (tsel && addr_hit)
        tag_q <= 1'b1;
    end
  end

  assign tag_pend_o = tag_q;
endmodule

// File: rtl/dbg_match_channel_chk.sv
module dbg_match_channel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] ctl_q,
  input logic       iq_flush,
  input logic       brk_enable,
  input logic       trig_o,
  input logic       tag_pend_o,
  input logic       brk_o,
  input logic       disarm_o
);
  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[0] |=> (!trig_o && !tag_pend_o));

  assert_tag_from_tagmode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tag_pend_o) |-> $past(ctl_q[1]));

  assert_tagged_trig_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && $past(ctl_q[1])) |-> $past(tag_pend_o));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    iq_flush |=> !tag_pend_o);

  assert_disarm_clears_tag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_o |-> !tag_pend_o);

  assert_brk_with_disarm_R12: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |-> (disarm_o && $past(brk_enable)));
endmodule

bind dbg_match_channel dbg_match_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .iq_flush(iq_flush),
  .brk_enable(brk_enable), .trig_o(trig_o), .tag_pend_o(tag_pend_o),
  .brk_o(brk_o), .disarm_o(disarm_o)
);

// File: tb/tb_dbg_match_channel.sv
module tb_dbg_match_channel;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [W-1:0] reg_wdata = '0;
  logic bus_valid = 1'b0, bus_rd = 1'b0;
  logic [W-1:0] bus_addr = '0, bus_data = '0, iq_exec_addr = '0;
  logic iq_exec = 1'b0, iq_flush = 1'b0, brk_enable = 1'b0;
  logic a_trig, a_tag, a_brk, a_dis, b_trig, b_tag, b_brk, b_dis;

  int checks = 0, fails = 0;
  logic [6:0] m_ctl = '0;
  logic [W-1:0] m_addr = '0, m_data = '0;
  logic m_tag_a = 1'b0, m_tag_b = 1'b0;

  always #2 clk = ~clk;

  dbg_match_channel #(.W(W), .HAS_INV(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .bus_valid(bus_valid), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_data(bus_data),
    .iq_exec(iq_exec), .iq_exec_addr(iq_exec_addr), .iq_flush(iq_flush),
    .brk_enable(brk_enable), .trig_o(a_trig), .tag_pend_o(a_tag), .brk_o(a_brk),
    .disarm_o(a_dis));

  dbg_match_channel #(.W(W), .HAS_INV(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .bus_valid(bus_valid), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_data(bus_data),
    .iq_exec(iq_exec), .iq_exec_addr(iq_exec_addr), .iq_flush(iq_flush),
    .brk_enable(brk_enable), .trig_o(b_trig), .tag_pend_o(b_tag), .brk_o(b_brk),
    .disarm_o(b_dis));

  // returns {next_tag, brk, disarm, trig}
  function automatic logic [3:0] model(input bit has_inv, input logic tag);
    logic en, tsel, hit, imm, fire, evt, kill, nt, dok;
    en   = m_ctl[0];
    tsel = m_ctl[1];
    hit  = en && bus_valid && (bus_addr == m_addr);
    dok  = !m_ctl[6] || ((bus_data == m_data) != (m_ctl[5] && has_inv));
    imm  = hit && !tsel && (!m_ctl[3] || (bus_rd == m_ctl[4])) && dok;
    fire = en && tsel && tag && iq_exec && !iq_flush && (iq_exec_addr == m_addr);
    evt  = imm || fire;
    kill = evt && m_ctl[2];
    if (!en || iq_flush || kill || fire) nt = 1'b0;
    else if (tsel && hit) nt = 1'b1;
    else nt = tag;
    return {nt, kill && brk_enable, kill, evt};
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input string req);
    logic [3:0] ea, eb;
    ea = model(1'b1, m_tag_a);
    eb = model(1'b0, m_tag_b);
    @(posedge clk);
    if (reg_we) begin
      case (reg_sel)
        2'd0: m_ctl = reg_wdata[6:0];
        2'd1: m_addr = reg_wdata;
        2'd2: m_data = reg_wdata;
        default: ;
      endcase
    end
    m_tag_a = ea[3];
    m_tag_b = eb[3];
    @(negedge clk);
    chk(req, "A trig", a_trig, ea[0]);
    chk(req, "A disarm", a_dis, ea[1]);
    chk(req, "A brk", a_brk, ea[2]);
    chk(req, "A tag", a_tag, ea[3]);
    chk(req, "B trig", b_trig, eb[0]);
    chk(req, "B disarm", b_dis, eb[1]);
    chk(req, "B brk", b_brk, eb[2]);
    chk(req, "B tag", b_tag, eb[3]);
  endtask

  task automatic idle();
    reg_we = 0; bus_valid = 0; iq_exec = 0; iq_flush = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] val);
    idle();
    reg_we = 1; reg_sel = sel; reg_wdata = val;
    step("R13");
    reg_we = 0;
  endtask

  task automatic bus(input logic [W-1:0] a, input logic [W-1:0] d, input logic rd, input string req);
    idle();
    bus_valid = 1; bus_addr = a; bus_data = d; bus_rd = rd;
    step(req);
    idle();
  endtask

  task automatic exe(input logic [W-1:0] a, input logic fl, input string req);
    idle();
    iq_exec = 1; iq_exec_addr = a; iq_flush = fl;
    step(req);
    idle();
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk("R1", "trig in reset", a_trig, 1'b0);
    chk("R1", "tag in reset", a_tag, 1'b0);
    chk("R1", "disarm in reset", a_dis, 1'b0);
    rst_n = 1;
    @(negedge clk);
    bus(16'h0000, 16'h0000, 1'b1, "R1");  // regs all zero: disabled
    wr(2'd1, 16'h1234);
    wr(2'd2, 16'h00AA);
    bus(16'h1234, 16'h00AA, 1'b0, "R2");  // still disabled
    wr(2'd0, 16'h0001);
    bus(16'h1234, 16'h0000, 1'b0, "R3");
    bus(16'h1235, 16'h0000, 1'b0, "R3");
    idle(); bus_addr = 16'h1234; step("R3");
    bus(16'h1234, 16'h0, 1'b1, "R6");
    wr(2'd0, 16'h0019);
    bus(16'h1234, 16'h0, 1'b1, "R4");
    bus(16'h1234, 16'h0, 1'b0, "R4");
    wr(2'd0, 16'h0009);
    bus(16'h1234, 16'h0, 1'b0, "R4");
    bus(16'h1234, 16'h0, 1'b1, "R4");
    wr(2'd0, 16'h0041);
    bus(16'h1234, 16'h00AA, 1'b0, "R5");
    bus(16'h1234, 16'h00AB, 1'b0, "R5");
    wr(2'd0, 16'h0061);
    bus(16'h1234, 16'h00AB, 1'b0, "R5");
    bus(16'h1234, 16'h00AA, 1'b0, "R5");
    wr(2'd0, 16'h006B);
    bus(16'h1234, 16'h00AA, 1'b1, "R7");
    exe(16'h1234, 1'b0, "R8");
    bus(16'h1234, 16'h0, 1'b0, "R7");
    exe(16'h1234, 1'b1, "R9");
    bus(16'h1234, 16'h0, 1'b0, "R7");
    iq_flush = 1; step("R9"); idle();
    bus(16'h1234, 16'h0, 1'b0, "R10");
    bus(16'h1234, 16'h5, 1'b1, "R10");
    exe(16'h1230, 1'b0, "R8");
    exe(16'h1234, 1'b0, "R10");
    exe(16'h1234, 1'b0, "R10");
    wr(2'd0, 16'h0000);
    bus(16'h1234, 16'h0, 1'b0, "R2");
    wr(2'd0, 16'h0005);
    brk_enable = 0;
    bus(16'h1234, 16'h0, 1'b0, "R12");
    brk_enable = 1;
    bus(16'h1234, 16'h0, 1'b0, "R12");
    wr(2'd0, 16'h0003);
    bus(16'h1234, 16'h0, 1'b0, "R7");
    wr(2'd0, 16'h0005);
    bus(16'h1234, 16'h0, 1'b0, "R11");
    wr(2'd0, 16'h0007);
    bus(16'h1234, 16'h0, 1'b0, "R7");
    exe(16'h1234, 1'b0, "R11");

    wr(2'd1, 16'h0040);
    wr(2'd2, 16'h0001);
    for (int i = 0; i < 3000; i++) begin
      reg_we     = ($urandom % 16) == 0;
      reg_sel    = 2'($urandom % 3);
      reg_wdata  = (reg_sel == 2'd0) ? W'($urandom % 128)
                 : (reg_sel == 2'd1) ? W'(16'h0040 + $urandom % 4) : W'($urandom % 4);
      bus_valid  = $urandom % 2;
      bus_rd     = $urandom % 2;
      bus_addr   = W'(16'h0040 + $urandom % 4);
      bus_data   = W'($urandom % 4);
      iq_exec    = ($urandom % 4) == 0;
      iq_exec_addr = W'(16'h0040 + $urandom % 4);
      iq_flush   = ($urandom % 8) == 0;
      brk_enable = $urandom % 2;
      step("R11/R8/R9 random");
    end
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule